// File: doc/BRIEF.md
# Reflected-order binary field multiplier

This block multiplies two elements of a binary extension field GF(2^N) stored in bit-reflected order. In that order the coefficient of degree 0 is the most significant bit of the vector, and degree N-1 is bit 0. The most significant byte, bits [N-1:N-8], is the first byte of the block. The product is reduced modulo a sparse polynomial that is fixed for each field size. The parameter `N` picks the size: 64, 96, 128, 192 or 256.

One operand, A, comes from the data stream. Its bytes may be reversed inside every 32-bit word, as a select input chooses. The other operand, K, is a precomputed key value and is always supplied in the internal order. A one-cycle `start` captures both operands. A single 64x64 carry-less multiplier is then reused over several cycles to build the full double-width product. The 256-bit size uses a Karatsuba split to cut the work from 16 partial products to 12. A one-bit shift then corrects the reflected product, and the reduction folds the upper half down in two passes. `done` pulses when `result` is valid. `result` keeps its value until the next operation completes.

Top module: `refl_gf_mul`

## Requirements
- R1: `result` equals A·K in GF(2^N), with both operands and the result in reflected order, where bit N-1-i holds the coefficient of t^i.
- R2: The modulus depends on N: t^64+t^4+t^3+t+1, t^96+t^10+t^9+t^6+1, t^128+t^7+t^2+t+1, t^192+t^7+t^2+t+1, t^256+t^10+t^5+t^2+1. Consequently t · t^(N-1) gives a result whose only set bits are N-1-k, for each low term t^k of the modulus.
- R3: When `swapBytes` is 1 at `start`, the four bytes of every 32-bit word of A (word w = bits [32w+31:32w]) are reversed before the multiply. The same reversal is applied to the result. When `swapBytes` is 0, no reordering is done.
- R4: When A is the reflected identity (bit N-1 set, all others clear, i.e. first byte 0x80) and `swapBytes` is 0, `result` equals K.
- R5: When A is zero, `result` is zero.
- R6: `done` is high for exactly one cycle. It rises at the clock edge that comes S+3 edges after the edge that samples `start`. S is the number of partial products: 1, 4, 4, 9 and 12 for N = 64, 96, 128, 192 and 256.
- R7: A `start` that arrives while an operation is in progress is ignored. The operation in progress keeps its operands and its timing.
- R8: After reset, `done` and `result` are zero. `result` changes only in the cycle in which `done` is high.
- R9: K is never byte-reordered, whatever the value of `swapBytes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; sampled only when idle |
| swapBytes | input | 1 | 1: A and result have bytes reversed within each 32-bit word |
| aIn | input | N | Operand A |
| kIn | input | N | Key operand K, internal reflected order |
| done | output | 1 | One-cycle completion pulse |
| result | output | N | Reduced product, held until the next completion |

## Verification
The checker monitors the handshake on every cycle. It confirms that `done` lasts one cycle, that it arrives exactly S+3 edges after an accepted `start`, that the block never becomes busy unless `start` is given, and that `result` never moves outside a `done` cycle. The field arithmetic can only be shown by the bench scenarios. Those scenarios cover every size against an independent bit-serial model, the polynomial probe t·t^(N-1), the identity, zero and all-ones operands, both byte orders, and a second `start` issued mid-operation with different operands.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

  // Strobes from the sequencer to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;      // capture operands, clear accumulator
    logic mulStep;   // accumulate one 64x64 partial product
    logic shiftFix;  // one-place correction of the reflected product
    logic foldHigh;  // first reduction pass (overflow of the upper half)
    logic finish;    // second reduction pass, register the result
  } rfmCtl_t;

  // Low-order terms t^k of the modulus (bit k set), the t^N term excluded.
  function automatic logic [15:0] tapMask(input int n);
    case (n)
      64:      tapMask = 16'b0000_0000_0001_1011;
      96:      tapMask = 16'b0000_0110_0100_0001;
      192:     tapMask = 16'b0000_0000_1000_0111;
      256:     tapMask = 16'b0000_0100_0010_0101;
      default: tapMask = 16'b0000_0000_1000_0111;
    endcase
  endfunction

  // Number of 64x64 partial products per multiply.
  function automatic int stepCount(input int n);
    int nw;
    nw = (n + 63) / 64;
    stepCount = (n == 256) ? 12 : nw * nw;
  endfunction

endpackage

// File: rtl/rfm_clmul64.sv
module rfm_clmul64 #(
  parameter int WID = 64
) (
  input  logic [WID-1:0]   opA,
  input  logic [WID-1:0]   opB,
  output logic [2*WID-1:0] prod
);
  always_comb begin
    prod = '0;
    for (int i = 0; i < WID; i++)
      if (opB[i]) prod = prod ^ ({{WID{1'b0}}, opA} << i);
  end
endmodule

// File: rtl/rfm_control.sv
module rfm_control
  import rfm_pkg::*;
#(
  parameter int NSTEP = 4,
  parameter int SW    = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output rfmCtl_t       ctl,
  output logic [SW-1:0] stepIdx,
  output logic          busy
);
  typedef enum logic [2:0] {S_IDLE, S_MUL, S_SHIFT, S_FOLD, S_REDUCE} state_t;
  state_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_MUL;
          stepIdx <= '0;
        end
        S_MUL: begin
          if (stepIdx == SW'(NSTEP - 1)) state <= S_SHIFT;
          else stepIdx <= stepIdx + 1'b1;
        end
        S_SHIFT:  state <= S_FOLD;
        S_FOLD:   state <= S_REDUCE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == S_IDLE) && start;
    ctl.mulStep  = (state == S_MUL);
    ctl.shiftFix = (state == S_SHIFT);
    ctl.foldHigh = (state == S_FOLD);
    ctl.finish   = (state == S_REDUCE);
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/rfm_datapath.sv
module rfm_datapath
  import rfm_pkg::*;
#(
  parameter int N  = 128,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  rfmCtl_t       ctl,
  input  logic [SW-1:0] stepIdx,
  input  logic          swapIn,
  input  logic [N-1:0]  aIn,
  input  logic [N-1:0]  kIn,
  output logic [N-1:0]  resOut,
  output logic          doneOut
);
  localparam int NW   = (N + 63) / 64;
  localparam int W    = 64 * NW;
  localparam bit KARA = (N == 256);
  localparam logic [15:0] TAPS = tapMask(N);

  logic [W-1:0]   aW, kW;
  logic [2*W-1:0] acc, accNext;
  logic [N-1:0]   hiFold, redOut, resReg;
  logic           swapReg, doneReg;
  logic [63:0]    opA, opB;
  logic [127:0]   prod;
  int             selA, selB, off1, off2;
  logic           dual;

  function automatic logic [N-1:0] swapLanes(input logic [N-1:0] x);
    logic [N-1:0] y;
    y = x;
    for (int w = 0; w < N / 32; w++)
      for (int b = 0; b < 4; b++)
        y[w*32 + b*8 +: 8] = x[w*32 + (3-b)*8 +: 8];
    return y;
  endfunction

  // Which word pair feeds the multiplier in this step, and where it lands.
  always_comb begin
    selA = 0; selB = 0; off1 = 0; off2 = 0; dual = 1'b0;
    if (KARA) begin
      selA = (int'(stepIdx) % 4) / 2;
      selB = int'(stepIdx) % 2;
      case (int'(stepIdx) / 4)
        0: begin off1 = selA + selB; off2 = off1 + 2; dual = 1'b1; end
        1: begin off1 = selA + selB + 4; off2 = off1 - 2; dual = 1'b1;
                 selA = selA + 2; selB = selB + 2; end
        default: begin off1 = selA + selB + 2; selA = selA + 4; selB = selB + 4; end
      endcase
    end else begin
      selA = int'(stepIdx) / NW;
      selB = int'(stepIdx) % NW;
      off1 = selA + selB;
    end
  end

  generate
    if (KARA) begin : gKaraSel
      // Words 4 and 5 are the half sums used for the middle Karatsuba term.
      assign opA = (selA < 4) ? aW[selA*64 +: 64] : (aW[(selA-4)*64 +: 64] ^ aW[(selA-2)*64 +: 64]);
      assign opB = (selB < 4) ? kW[selB*64 +: 64] : (kW[(selB-4)*64 +: 64] ^ kW[(selB-2)*64 +: 64]);
    end else begin : gPlainSel
      assign opA = aW[selA*64 +: 64];
      assign opB = kW[selB*64 +: 64];
    end
  endgenerate

  rfm_clmul64 #(.WID(64)) u_clmul (.opA(opA), .opB(opB), .prod(prod));

  always_comb begin
    accNext = acc;
    accNext[off1*64 +: 128] = accNext[off1*64 +: 128] ^ prod;
    if (dual) accNext[off2*64 +: 128] = accNext[off2*64 +: 128] ^ prod;
  end

  // Pass 1: bits of the upper half that would wrap past t^(N-1) again.
  always_comb begin
    hiFold = acc[N-1:0];
    for (int k = 1; k < 16; k++)
      if (TAPS[k]) hiFold = hiFold ^ (acc[N-1:0] << (N - k));
  end

  // Pass 2: fold the corrected upper half into the lower half.
  always_comb begin
    redOut = acc[2*N-1:N];
    for (int k = 0; k < 16; k++)
      if (TAPS[k]) redOut = redOut ^ (acc[N-1:0] >> k);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aW <= '0; kW <= '0; acc <= '0;
      swapReg <= 1'b0; resReg <= '0; doneReg <= 1'b0;
    end else begin
      doneReg <= ctl.finish;
      if (ctl.load) begin
        aW      <= W'(swapIn ? swapLanes(aIn) : aIn);
        kW      <= W'(kIn);
        swapReg <= swapIn;
        acc     <= '0;
      end else if (ctl.mulStep) begin
        acc <= accNext;
      end else if (ctl.shiftFix) begin
        acc <= acc << 1;
      end else if (ctl.foldHigh) begin
        acc[N-1:0] <= hiFold;
      end
      if (ctl.finish) resReg <= swapReg ? swapLanes(redOut) : redOut;
    end
  end

  assign resOut  = resReg;
  assign doneOut = doneReg;
endmodule

// File: rtl/refl_gf_mul.sv
module refl_gf_mul
  import rfm_pkg::*;
#(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         swapBytes,
  input  logic [N-1:0] aIn,
  input  logic [N-1:0] kIn,
  output logic         done,
  output logic [N-1:0] result
);
  localparam int NSTEP = stepCount(N);
  localparam int SW    = $clog2(NSTEP + 1);

  rfmCtl_t       ctl;
  logic [SW-1:0] stepIdx;
  logic          busy;

  rfm_control #(.NSTEP(NSTEP), .SW(SW)) u_control (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .stepIdx(stepIdx), .busy(busy)
  );

  rfm_datapath #(.N(N), .SW(SW)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stepIdx(stepIdx),
    .swapIn(swapBytes), .aIn(aIn), .kIn(kIn),
    .resOut(result), .doneOut(done)
  );
endmodule

// File: rtl/refl_gf_mul_chk.sv
module refl_gf_mul_chk #(
  parameter int N = 128
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] result
);
  localparam int NSTEP = rfm_pkg::stepCount(N);
  localparam int LAT   = NSTEP + 4;

  int cnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= 0;
    else if (start && !busy) cnt <= 1;
    else if (busy) cnt <= cnt + 1;
  end

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cnt == LAT));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7: work only begins on a start; a start seen while busy cannot extend or restart it
  a_r7_no_self_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !busy);

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));
endmodule

bind refl_gf_mul refl_gf_mul_chk #(.N(N)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .result(result)
);

// File: tb/test_refl_gf_mul.sv
`timescale 1ns/1ps
module test_refl_gf_mul;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic swapSel = 1'b0;
  logic [255:0] aBus [5];
  logic [255:0] kBus [5];
  logic [255:0] resBus [5];
  logic         doneV [5];
  int checks = 0;
  int errs = 0;

  always #4 clk = ~clk;

  function automatic int szOf(input int g);
    case (g) 0: return 64; 1: return 96; 2: return 128; 3: return 192; default: return 256; endcase
  endfunction

  function automatic int latOf(input int g);
    case (g) 0: return 4; 1: return 7; 2: return 7; 3: return 12; default: return 15; endcase
  endfunction

  for (genvar g = 0; g < 5; g++) begin : gSz
    localparam int W = (g == 0) ? 64 : (g == 1) ? 96 : (g == 2) ? 128 : (g == 3) ? 192 : 256;
    logic [W-1:0] resLoc;
    logic         doneLoc;
    refl_gf_mul #(.N(W)) i_refl_gf_mul (
      .clk(clk), .rstN(rstN), .start(start), .swapBytes(swapSel),
      .aIn(aBus[g][W-1:0]), .kIn(kBus[g][W-1:0]),
      .done(doneLoc), .result(resLoc)
    );
    assign resBus[g] = 256'(resLoc);
    assign doneV[g]  = doneLoc;
  end

  function automatic logic [255:0] maskOf(input int n);
    return (n == 256) ? {256{1'b1}} : ((256'd1 << n) - 256'd1);
  endfunction

  function automatic logic [255:0] polyLow(input int n);
    logic [255:0] r = '0;
    case (n)
      64:  begin r[n-1] = 1; r[n-2] = 1; r[n-4] = 1; r[n-5] = 1; end
      96:  begin r[n-1] = 1; r[n-7] = 1; r[n-10] = 1; r[n-11] = 1; end
      256: begin r[n-1] = 1; r[n-3] = 1; r[n-6] = 1; r[n-11] = 1; end
      default: begin r[n-1] = 1; r[n-2] = 1; r[n-3] = 1; r[n-8] = 1; end
    endcase
    return r;
  endfunction

  // Bit-serial reflected-order multiply with per-step reduction.
  function automatic logic [255:0] refMul(input int n, input logic [255:0] a, input logic [255:0] b);
    logic [255:0] z = '0;
    logic [255:0] v = b;
    logic lsb;
    for (int i = 0; i < n; i++) begin
      if (a[n-1-i]) z = z ^ v;
      lsb = v[0];
      v = v >> 1;
      if (lsb) v = v ^ polyLow(n);
    end
    return z;
  endfunction

  function automatic logic [255:0] swp(input int n, input logic [255:0] x);
    logic [255:0] y = x;
    for (int w = 0; w < n / 32; w++)
      for (int b = 0; b < 4; b++)
        y[w*32 + b*8 +: 8] = x[w*32 + (3-b)*8 +: 8];
    return y;
  endfunction

  function automatic logic [255:0] expOf(input int n, input bit sw, input logic [255:0] a, input logic [255:0] k);
    logic [255:0] r;
    r = refMul(n, sw ? swp(n, a) : a, k);
    return sw ? swp(n, r) : r;
  endfunction

  function automatic logic [255:0] rnd(input int n);
    logic [255:0] x;
    for (int i = 0; i < 8; i++) x[i*32 +: 32] = $urandom;
    return x & maskOf(n);
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one multiply on all five sizes; expVal holds the expected results.
  task automatic runOp(input bit sw, input bit glitch, input bit chkLat, input string req,
                       input logic [255:0] expVal [5]);
    bit seen [5];
    int lat [5];
    logic [255:0] got [5];
    int nSeen = 0;
    for (int g = 0; g < 5; g++) begin seen[g] = 0; lat[g] = -1; got[g] = '0; end
    @(negedge clk);
    swapSel = sw;
    start = 1'b1;
    for (int cyc = 0; cyc < 40 && nSeen < 5; cyc++) begin
      @(negedge clk);
      if (cyc == 0) start = 1'b0;
      if (glitch && cyc == 2) begin
        start = 1'b1;
        for (int g = 0; g < 5; g++) begin
          aBus[g] = ~aBus[g] & maskOf(szOf(g));
          kBus[g] = ~kBus[g] & maskOf(szOf(g));
        end
      end
      if (glitch && cyc == 3) start = 1'b0;
      for (int g = 0; g < 5; g++)
        if (!seen[g] && doneV[g]) begin
          seen[g] = 1; lat[g] = cyc; got[g] = resBus[g]; nSeen++;
        end
    end
    for (int g = 0; g < 5; g++) begin
      check(seen[g] && got[g] == expVal[g], req, got[g], expVal[g]);
      if (chkLat) check(lat[g] == latOf(g), "R6 latency", 256'(lat[g]), 256'(latOf(g)));
    end
  endtask

  task automatic checkHold(input string req);
    logic [255:0] snap [5];
    for (int g = 0; g < 5; g++) snap[g] = resBus[g];
    repeat (4) @(negedge clk);
    for (int g = 0; g < 5; g++) begin
      check(resBus[g] == snap[g] && !doneV[g], req, resBus[g], snap[g]);
    end
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [255:0] ex [5];
    int n;
    void'($urandom(32'd20240611));
    for (int g = 0; g < 5; g++) begin aBus[g] = '0; kBus[g] = '0; end
    repeat (3) @(negedge clk);
    // R8: reset state
    for (int g = 0; g < 5; g++) check(!doneV[g] && resBus[g] == '0, "R8 reset", resBus[g], '0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 identity, plain order; R6 latency measured here
    for (int g = 0; g < 5; g++) begin
      n = szOf(g); aBus[g] = 256'd1 << (n - 1); kBus[g] = rnd(n); ex[g] = kBus[g];
    end
    runOp(1'b0, 1'b0, 1'b1, "R4 identity", ex);
    checkHold("R8 hold");

    // R3 and R9: identity in swapped order returns K swapped, K itself untouched
    for (int g = 0; g < 5; g++) begin
      n = szOf(g); aBus[g] = swp(n, 256'd1 << (n - 1)); kBus[g] = rnd(n); ex[g] = swp(n, kBus[g]);
    end
    runOp(1'b1, 1'b0, 1'b0, "R3 R9 swapped identity", ex);

    // R5 zero operand
    for (int g = 0; g < 5; g++) begin
      n = szOf(g); aBus[g] = '0; kBus[g] = rnd(n); ex[g] = '0;
    end
    runOp(1'b1, 1'b0, 1'b0, "R5 zero", ex);

    // R2 modulus probe: t times t^(N-1)
    for (int g = 0; g < 5; g++) begin
      n = szOf(g); aBus[g] = 256'd1 << (n - 2); kBus[g] = 256'd1; ex[g] = polyLow(n);
    end
    runOp(1'b0, 1'b0, 1'b0, "R2 modulus", ex);

    // R1 all-ones operands
    for (int g = 0; g < 5; g++) begin
      n = szOf(g); aBus[g] = maskOf(n); kBus[g] = maskOf(n); ex[g] = expOf(n, 1'b0, aBus[g], kBus[g]);
    end
    runOp(1'b0, 1'b0, 1'b0, "R1 all ones", ex);

    // R7 second start mid-operation with different operands
    for (int g = 0; g < 5; g++) begin
      n = szOf(g); aBus[g] = rnd(n); kBus[g] = rnd(n); ex[g] = expOf(n, 1'b1, aBus[g], kBus[g]);
    end
    runOp(1'b1, 1'b1, 1'b1, "R7 start while busy", ex);
    checkHold("R8 hold after ignored start");

    // R1 R3 random operands in both byte orders
    for (int t = 0; t < 40; t++) begin
      for (int g = 0; g < 5; g++) begin
        n = szOf(g); aBus[g] = rnd(n); kBus[g] = rnd(n);
        ex[g] = expOf(n, t[0], aBus[g], kBus[g]);
      end
      runOp(t[0], 1'b0, 1'b0, t[0] ? "R1 R3 random swapped" : "R1 random plain", ex);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule